// File: doc/BRIEF.md
# Floating-Point Compare Predicate Evaluator

This block compares two single-precision IEEE-754 words and reports whether a chosen relation between them holds. A 3-bit predicate code picks the relation. The block first finds out whether the operand pair is ordered. Each code then gives a fixed answer when the pair is unordered, and otherwise gives the result of the relation itself. The answer appears as a one-bit flag and as a 32-bit lane mask that is all ones or all zeros, so it can drive a select or blend directly.

The relations greater-than and greater-or-equal have no codes of their own. A caller reaches them, or their negations, by setting a swap request, which exchanges the two operands before evaluation. Operands, code and swap request are captured on an input strobe. The result is presented one clock later, together with an output strobe.

Top module: `fpcmp_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it, out_valid, cmp_true and lane_mask are all zero.
- R2: When in_valid is high at a rising edge, out_valid is high for exactly the following cycle, and the result is computed from the inputs captured at that edge. While in_valid is low, changes on op_a, op_b, pred and swap_req have no effect on cmp_true.
- R3: Code 000 (equal) is true for equal non-NaN operands, and +0 (32'h0000_0000) equals -0 (32'h8000_0000). Code 100 (not-equal) is its complement for ordered pairs.
- R4: Code 001 (less-than) and code 010 (less-or-equal) follow numeric order for ordered operands, across signs and infinities (exponent 255 with zero fraction).
- R5: A word is NaN when its exponent field (bits 30:23) is 255 and its fraction (bits 22:0) is nonzero. A pair is unordered if either word is NaN. For an unordered pair, codes 000, 001, 010 and 111 give false, and codes 011, 100, 101 and 110 give true.
- R6: For an ordered pair, code 101 gives NOT(A < B) and code 110 gives NOT(A <= B).
- R7: With swap_req high, A and B are exchanged before evaluation. Code 101 with swap then gives not-greater-than, and code 110 with swap gives not-greater-or-equal.
- R8: Greater-than, formed as code 001 with swap, is false when either operand is NaN, while code 110 without swap is true on the same operands.
- R9: lane_mask is 32'hFFFF_FFFF whenever cmp_true is 1, and zero otherwise.
- R10: Code 111 (ordered) is true exactly when neither operand is NaN, and code 011 (unordered) is true exactly when at least one is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Capture strobe for operands, code and swap request |
| op_a | input | 32 | First single-precision operand |
| op_b | input | 32 | Second single-precision operand |
| pred | input | 3 | Predicate code |
| swap_req | input | 1 | Exchange the operands before evaluation |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| cmp_true | output | 1 | Predicate result |
| lane_mask | output | 32 | All ones when cmp_true is set, else zero |

## Verification
Ordered pairs cover equal values, both signed zeros, values of mixed sign and infinities. These show whether the order is decided on sign and magnitude or on the raw bit pattern. Quiet NaNs, the smallest NaN encoding and negative NaNs run through all eight codes. This separates the fixed unordered answers from the relation itself, and it catches a NaN test that looks only at the exponent. Swapped requests use asymmetric operand pairs, with and without a NaN, so that greater-than is told apart from not-less-or-equal. A hold case changes the inputs while the strobe is low to show that only captured values reach the result.

// File: rtl/fpcmp_pkg.sv
// Package: shared widths, predicate encoding and operand class record.
// Assumes single-precision field layout; widths are kept as parameters so
// the classifier can be reused for other binary formats.
package fpcmp_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MAG_W  = EXP_W + FRAC_W;

    // Predicate codes; the lower half are the positive relations, the
    // upper half their complements (same answer order, inverted).
    typedef enum logic [2:0] {
        PRED_EQ    = 3'b000,
        PRED_LT    = 3'b001,
        PRED_LE    = 3'b010,
        PRED_UNORD = 3'b011,
        PRED_NEQ   = 3'b100,
        PRED_NLT   = 3'b101,
        PRED_NLE   = 3'b110,
        PRED_ORD   = 3'b111
    } pred_e;

    // Per-operand classification used by the relation stage.
    typedef struct packed {
        logic             sign;
        logic             is_nan;
        logic             is_zero;
        logic [MAG_W-1:0] mag;
    } fp_class_t;

endpackage

// File: rtl/fpcmp_classify.sv
// Module: fpcmp_classify
// Splits one floating-point word into sign, magnitude, zero and NaN flags.
// Assumes sign in the top bit, then the exponent, then the fraction.
module fpcmp_classify
    import fpcmp_pkg::*;
#(
    parameter int P_EXP_W  = EXP_W,
    parameter int P_FRAC_W = FRAC_W
) (
    input  logic [P_EXP_W+P_FRAC_W:0] word_in,
    output fp_class_t                 cls_out
);

    localparam int P_MAG_W = P_EXP_W + P_FRAC_W;

    logic [P_EXP_W-1:0]  exp_f;
    logic [P_FRAC_W-1:0] frac_f;

    assign exp_f  = word_in[P_MAG_W-1:P_FRAC_W];
    assign frac_f = word_in[P_FRAC_W-1:0];

    // Purpose: derive the class record from the raw fields.
    always_comb begin
        cls_out.sign    = word_in[P_MAG_W];
        cls_out.mag     = word_in[P_MAG_W-1:0];
        cls_out.is_zero = (word_in[P_MAG_W-1:0] == '0);
        cls_out.is_nan  = (&exp_f) && (frac_f != '0);
    end

endmodule

// File: rtl/fpcmp_relate.sv
// Module: fpcmp_relate
// Computes unordered, equal and less-than for two classified operands.
// Assumes sign-magnitude encoding; eq and lt are meaningful only when
// the pair is ordered.
module fpcmp_relate
    import fpcmp_pkg::*;
(
    input  fp_class_t cls_a,
    input  fp_class_t cls_b,
    output logic      unord,
    output logic      eq,
    output logic      lt
);

    logic both_zero;
    logic mag_lt;
    logic mag_gt;

    assign both_zero = cls_a.is_zero && cls_b.is_zero;
    assign mag_lt    = cls_a.mag < cls_b.mag;
    assign mag_gt    = cls_b.mag < cls_a.mag;

    // Purpose: order the operands by sign first, then by magnitude.
    always_comb begin
        unord = cls_a.is_nan || cls_b.is_nan;
        eq    = both_zero ||
                ((cls_a.sign == cls_b.sign) && (cls_a.mag == cls_b.mag));
        if (both_zero) begin
            lt = 1'b0;
        end else if (cls_a.sign != cls_b.sign) begin
            lt = cls_a.sign;
        end else if (cls_a.sign) begin
            lt = mag_gt;
        end else begin
            lt = mag_lt;
        end
    end

endmodule

// File: rtl/fpcmp_select.sv
// Module: fpcmp_select
// Chooses the predicate answer from the relation flags.
// Assumes bit 2 of the code inverts the answer of the lower code, which
// also yields the unordered answers (false low half, true high half,
// except the unordered/ordered pair).
module fpcmp_select
    import fpcmp_pkg::*;
(
    input  logic [2:0] pred,
    input  logic       unord,
    input  logic       eq,
    input  logic       lt,
    output logic       result
);

    logic base;

    // Purpose: evaluate the positive relation selected by the low bits.
    always_comb begin
        unique case (pred_e'({1'b0, pred[1:0]}))
            PRED_EQ:    base = !unord && eq;
            PRED_LT:    base = !unord && lt;
            PRED_LE:    base = !unord && (lt || eq);
            default:    base = unord;
        endcase
    end

    assign result = base ^ pred[2];

endmodule

// File: rtl/fpcmp_unit.sv
// Module: fpcmp_unit (top)
// Captures operands, code and swap request on in_valid, then evaluates
// the predicate from the captured values; result and mask are valid in
// the cycle after the strobe. Assumes synchronous active-low reset.
module fpcmp_unit
    import fpcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [2:0]        pred,
    input  logic              swap_req,
    output logic              out_valid,
    output logic              cmp_true,
    output logic [WORD_W-1:0] lane_mask
);

    localparam int NUM_OPS = 2;

    logic [WORD_W-1:0] a_q, b_q;
    logic [2:0]        pred_q;
    logic              swap_q;
    logic              valid_q;

    logic [WORD_W-1:0] opnd [NUM_OPS];
    fp_class_t         cls  [NUM_OPS];
    logic              unord, eq, lt, result;

    // Purpose: capture the request on the input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q     <= '0;
            b_q     <= '0;
            pred_q  <= PRED_EQ;
            swap_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                a_q    <= op_a;
                b_q    <= op_b;
                pred_q <= pred;
                swap_q <= swap_req;
            end
        end
    end

    // Purpose: exchange the operands when a swap was requested.
    always_comb begin
        opnd[0] = swap_q ? b_q : a_q;
        opnd[1] = swap_q ? a_q : b_q;
    end

    // One classifier per operand.
    for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_cls
        fpcmp_classify #(.P_EXP_W(EXP_W), .P_FRAC_W(FRAC_W)) u_cls (
            .word_in (opnd[gi]),
            .cls_out (cls[gi])
        );
    end

    fpcmp_relate u_rel (
        .cls_a (cls[0]),
        .cls_b (cls[1]),
        .unord (unord),
        .eq    (eq),
        .lt    (lt)
    );

    fpcmp_select u_sel (
        .pred   (pred_q),
        .unord  (unord),
        .eq     (eq),
        .lt     (lt),
        .result (result)
    );

    // Result is gated by the output strobe so idle cycles read as false.
    assign out_valid = valid_q;
    assign cmp_true  = valid_q && result;
    assign lane_mask = {WORD_W{cmp_true}};

endmodule

// File: rtl/fpcmp_unit_checker.sv
// Module: fpcmp_unit_checker
// Port-level temporal checks for fpcmp_unit, attached with bind.
module fpcmp_unit_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic [2:0]  pred,
    input logic        swap_req,
    input logic        out_valid,
    input logic        cmp_true,
    input logic [31:0] lane_mask
);

    function automatic logic is_nan_w(input logic [31:0] w);
        return (w[30:23] == 8'hFF) && (w[22:0] != 23'd0);
    endfunction

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !cmp_true));

    assert_strobe_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    assert_signed_zero_eq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred == 3'b000 && op_a[30:0] == 31'd0 && op_b[30:0] == 31'd0)
        |=> cmp_true);

    assert_unordered_false_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred[1:0] != 2'b11 && !pred[2] && (is_nan_w(op_a) || is_nan_w(op_b)))
        |=> !cmp_true);

    assert_unordered_true_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred[2] && pred != 3'b111 && (is_nan_w(op_a) || is_nan_w(op_b)))
        |=> cmp_true);

    assert_mask_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lane_mask == {32{cmp_true}});

    assert_ordered_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred == 3'b111)
        |=> (cmp_true == !(is_nan_w($past(op_a)) || is_nan_w($past(op_b)))));

endmodule

bind fpcmp_unit fpcmp_unit_checker chk (.*);

// File: tb/fpcmp_unit_test.sv
// Directed bench for fpcmp_unit; each scenario task checks its own results.
module fpcmp_unit_test;

    localparam logic [31:0] P_ONE  = 32'h3F80_0000;
    localparam logic [31:0] P_TWO  = 32'h4000_0000;
    localparam logic [31:0] N_ONE  = 32'hBF80_0000;
    localparam logic [31:0] N_TWO  = 32'hC000_0000;
    localparam logic [31:0] P_ZERO = 32'h0000_0000;
    localparam logic [31:0] N_ZERO = 32'h8000_0000;
    localparam logic [31:0] P_INF  = 32'h7F80_0000;
    localparam logic [31:0] N_INF  = 32'hFF80_0000;
    localparam logic [31:0] Q_NAN  = 32'h7FC0_0000;
    localparam logic [31:0] MIN_NAN= 32'h7F80_0001;
    localparam logic [31:0] NEG_NAN= 32'hFFC0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [2:0]  pred = '0;
    logic        swap_req = 1'b0;
    logic        out_valid;
    logic        cmp_true;
    logic [31:0] lane_mask;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fpcmp_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .pred(pred), .swap_req(swap_req),
        .out_valid(out_valid), .cmp_true(cmp_true), .lane_mask(lane_mask)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one request and check strobe, result and mask a cycle later.
    task automatic run_cmp(input logic [31:0] a, input logic [31:0] b,
                           input logic [2:0] p, input logic sw,
                           input logic exp, input string req);
        @(negedge clk);
        op_a = a; op_b = b; pred = p; swap_req = sw; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " out_valid (R2)"}, {31'd0, out_valid}, 32'd1);
        check(req, {31'd0, cmp_true}, {31'd0, exp});
        check({req, " mask (R9)"}, lane_mask, {32{exp}});
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 cmp_true", {31'd0, cmp_true}, 32'd0);
        check("R1 lane_mask", lane_mask, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic test_equal();
        run_cmp(P_ONE,  P_ONE,  3'b000, 1'b0, 1'b1, "R3 eq same");
        run_cmp(P_ZERO, N_ZERO, 3'b000, 1'b0, 1'b1, "R3 +0==-0");
        run_cmp(N_ZERO, P_ZERO, 3'b100, 1'b0, 1'b0, "R3 neq zeros");
        run_cmp(P_ONE,  N_ONE,  3'b000, 1'b0, 1'b0, "R3 eq sign differs");
        run_cmp(P_ONE,  P_TWO,  3'b100, 1'b0, 1'b1, "R3 neq");
    endtask

    task automatic test_order();
        run_cmp(P_ONE, P_TWO, 3'b001, 1'b0, 1'b1, "R4 1<2");
        run_cmp(P_TWO, P_ONE, 3'b001, 1'b0, 1'b0, "R4 2<1");
        run_cmp(N_TWO, N_ONE, 3'b001, 1'b0, 1'b1, "R4 -2<-1");
        run_cmp(N_ONE, N_TWO, 3'b001, 1'b0, 1'b0, "R4 -1<-2");
        run_cmp(N_ONE, P_ONE, 3'b001, 1'b0, 1'b1, "R4 -1<1");
        run_cmp(N_ZERO, P_ZERO, 3'b001, 1'b0, 1'b0, "R4 -0<+0");
        run_cmp(N_INF, N_TWO, 3'b001, 1'b0, 1'b1, "R4 -inf<-2");
        run_cmp(P_INF, P_INF, 3'b010, 1'b0, 1'b1, "R4 inf<=inf");
        run_cmp(P_TWO, P_ONE, 3'b010, 1'b0, 1'b0, "R4 2<=1");
        run_cmp(P_ONE, P_ONE, 3'b010, 1'b0, 1'b1, "R4 1<=1");
    endtask

    task automatic test_nan();
        for (int p = 0; p < 8; p++) begin
            logic e;
            e = (p == 3) || (p == 4) || (p == 5) || (p == 6);
            run_cmp(Q_NAN, P_ONE, 3'(p), 1'b0, e, $sformatf("R5 qnan code %0d", p));
            run_cmp(N_TWO, MIN_NAN, 3'(p), 1'b0, e, $sformatf("R5 min nan code %0d", p));
        end
        run_cmp(NEG_NAN, NEG_NAN, 3'b000, 1'b0, 1'b0, "R5 nan==nan");
        run_cmp(P_INF, N_INF, 3'b111, 1'b0, 1'b1, "R10 ord infs");
        run_cmp(P_INF, N_INF, 3'b011, 1'b0, 1'b0, "R10 unord infs");
        run_cmp(NEG_NAN, P_ZERO, 3'b011, 1'b0, 1'b1, "R10 unord nan");
    endtask

    task automatic test_negated();
        run_cmp(P_ONE, P_TWO, 3'b101, 1'b0, 1'b0, "R6 nlt 1,2");
        run_cmp(P_TWO, P_ONE, 3'b101, 1'b0, 1'b1, "R6 nlt 2,1");
        run_cmp(P_ONE, P_ONE, 3'b110, 1'b0, 1'b0, "R6 nle 1,1");
        run_cmp(P_TWO, N_ONE, 3'b110, 1'b0, 1'b1, "R6 nle 2,-1");
    endtask

    task automatic test_swap();
        run_cmp(P_TWO, P_ONE, 3'b101, 1'b1, 1'b0, "R7 ngt 2,1");
        run_cmp(P_ONE, P_TWO, 3'b101, 1'b1, 1'b1, "R7 ngt 1,2");
        run_cmp(P_ONE, P_ONE, 3'b110, 1'b1, 1'b0, "R7 nge 1,1");
        run_cmp(N_TWO, P_ONE, 3'b110, 1'b1, 1'b1, "R7 nge -2,1");
        run_cmp(P_TWO, P_ONE, 3'b001, 1'b1, 1'b1, "R8 gt ordered");
        run_cmp(Q_NAN, P_ONE, 3'b001, 1'b1, 1'b0, "R8 gt nan");
        run_cmp(Q_NAN, P_ONE, 3'b110, 1'b0, 1'b1, "R8 nle nan");
    endtask

    task automatic test_hold();
        run_cmp(P_ONE, P_TWO, 3'b001, 1'b0, 1'b1, "R2 setup");
        op_a = P_TWO; op_b = P_ONE; pred = 3'b000; swap_req = 1'b1;
        @(negedge clk);
        check("R2 strobe drops", {31'd0, out_valid}, 32'd0);
        check("R2 idle result", {31'd0, cmp_true}, 32'd0);
        @(negedge clk);
        in_valid = 1'b1;
        op_a = P_ONE; op_b = P_TWO; pred = 3'b001; swap_req = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        op_a = Q_NAN; pred = 3'b000;
        check("R2 captured inputs only", {31'd0, cmp_true}, 32'd1);
    endtask

    initial begin
        test_reset();
        test_equal();
        test_order();
        test_nan();
        test_negated();
        test_swap();
        test_hold();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule